// File: doc/BRIEF.md
# Single-Wait-State Tightly-Coupled Memory Read Controller

This block connects a processor's tightly-coupled memory read port to a synchronous memory array that needs one extra cycle for every read. The processor side presents a chip select, a read strobe and an address. The controller returns read data and a wait indication. The wait indication is pipelined: its value describes the cycle that follows the one after a request, not the cycle in which it is seen. It is generated ahead of time, so it stays high while nothing is happening and the processor ignores it then.

A two-state sequencer inserts exactly one wait state per read. In the idle state the wait output is high. When a request is accepted, the sequencer moves to a busy state for one cycle and drops the wait output. That low value tells the processor the read finishes in the next cycle. In that completion cycle the wait output is high again, the data is valid, and a new request may be presented. Reads issued back to back therefore run at one every two cycles. A small behavioural memory array, sized by parameters, sits inside the block. A bench can preload it so the block can be checked on its own.

The processor read port is a fixed-timing protocol and has no valid/ready pair. The wait pin is its only means of applying back-pressure. A request presented while the wait output is low is not accepted and has no effect. The wait output and the data bus are plain outputs.

Top module: `tcmw_ctrl`

## Requirements
- R1: While reset is high at a rising edge, the block returns to idle. In the cycle after that edge, `wait_o` is 1 and `rdata_o` is 0.
- R2: A request is accepted at a rising edge only if `req_cs_i` and `req_rd_i` are both 1 and `wait_o` is 1 in that cycle. The address is captured at that edge. In the following cycle `wait_o` is 0.
- R3: `wait_o` is 0 for exactly one cycle per accepted request. In the cycle after that it is 1 again; this is the completion cycle.
- R4: In the completion cycle, which is two cycles after the request cycle, `rdata_o` equals the memory word at the captured address.
- R5: `rdata_o` changes only at the edge that begins a completion cycle. It holds its value in every other cycle.
- R6: A request presented in a completion cycle is accepted. Continuous requests complete one every two cycles.
- R7: While idle with no request, `wait_o` stays 1. This is the speculative wait value.
- R8: Chip select without the read strobe, or the read strobe without chip select, is not a request. `wait_o` stays 1 and `rdata_o` does not change.
- R9: A request presented while `wait_o` is 0 is ignored. The data of the pending read comes from the address captured earlier, and `wait_o` returns to 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_cs_i | input | 1 | Chip select for the memory port |
| req_rd_i | input | 1 | Read strobe |
| req_addr_i | input | AW | Word address of the read |
| wait_o | output | 1 | Pipelined wait; low means the read in progress completes in the next cycle |
| rdata_o | output | DW | Read data, valid in the completion cycle and held until the next completion |

## Verification
The hardest case to reach is a request held high through the busy cycle while its address keeps changing. This case shows whether the address of an ignored request can leak into the pending read. The stimulus holds chip select and the read strobe high for many cycles in a row and gives a new address every cycle. The scoreboard then expects data only from the addresses on the idle and completion cycles. Isolated reads, idle gaps and single-strobe patterns complete the stimulus.

// File: rtl/tcmw_pkg.sv
package tcmw_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;
endpackage

// File: rtl/tcmw_seq.sv
// Two-state sequencer: one wait state per read.
module tcmw_seq
  import tcmw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  output logic accept_o,
  output logic fetch_o,
  output logic wait_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    unique case (state_q)
      SEQ_IDLE: if (req_i) begin
        accept_o = 1'b1;
        state_d  = SEQ_BUSY;
      end
      SEQ_BUSY: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= state_d;
  end

  // Speculative: high whenever idle, whether or not a request exists.
  assign wait_o  = (state_q == SEQ_IDLE);
  assign fetch_o = (state_q == SEQ_BUSY);
endmodule

// File: rtl/tcmw_areg.sv
// Captures the address of an accepted request.
module tcmw_areg #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst)         addr_o <= '0;
    else if (load_i) addr_o <= addr_i;
  end
endmodule

// File: rtl/tcmw_sram.sv
// Behavioural synchronous-read array with a registered output.
module tcmw_sram #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o
);
  localparam int Depth = 1 << AW;

  logic [DW-1:0] mem_q [Depth];

  initial begin
    for (int i = 0; i < Depth; i++) mem_q[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)          data_o <= '0;
    else if (rd_en_i) data_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/tcmw_ctrl.sv
module tcmw_ctrl #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_cs_i,
  input  logic          req_rd_i,
  input  logic [AW-1:0] req_addr_i,
  output logic          wait_o,
  output logic [DW-1:0] rdata_o
);
  logic          req;
  logic          accept;
  logic          fetch;
  logic [AW-1:0] addr_q;

  assign req = req_cs_i & req_rd_i;

  tcmw_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req),
    .accept_o (accept),
    .fetch_o  (fetch),
    .wait_o   (wait_o)
  );

  tcmw_areg #(.AW(AW)) u_areg (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .addr_i (req_addr_i),
    .addr_o (addr_q)
  );

  tcmw_sram #(.DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .rd_en_i (fetch),
    .addr_i  (addr_q),
    .data_o  (rdata_o)
  );
endmodule

// File: rtl/tcmw_ctrl_chk.sv
module tcmw_ctrl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_cs_i,
  input logic          req_rd_i,
  input logic          wait_o,
  input logic [DW-1:0] rdata_o
);
  // R2
  accept_drops_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_o && req_cs_i && req_rd_i) |=> !wait_o);

  // R3
  single_wait_state_chk: assert property (@(posedge clk) disable iff (rst)
    !wait_o |=> wait_o);

  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wait_o |=> $stable(rdata_o));

  // R7
  idle_wait_high_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_o && !req_cs_i && !req_rd_i) |=> wait_o);

  // R8
  partial_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_o && (req_cs_i != req_rd_i)) |=> (wait_o && $stable(rdata_o)));
endmodule

bind tcmw_ctrl tcmw_ctrl_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_cs_i (req_cs_i),
  .req_rd_i (req_rd_i),
  .wait_o   (wait_o),
  .rdata_o  (rdata_o)
);

// File: tb/tcmw_ctrl_test.sv
module tcmw_ctrl_test;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int Depth = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs = 1'b0;
  logic          rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wait_s;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] model [Depth];
  logic [DW-1:0] sb_q [$];
  logic          exp_busy = 1'b0;
  logic          exp_cmpl = 1'b0;
  logic [DW-1:0] held = '0;
  bit            mon_on = 1'b0;
  int            completions = 0;

  tcmw_ctrl #(.DW(DW), .AW(AW)) uut (
    .clk        (clk),
    .rst        (rst),
    .req_cs_i   (cs),
    .req_rd_i   (rd),
    .req_addr_i (addr),
    .wait_o     (wait_s),
    .rdata_o    (rdata)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: accepts only when idle; pushes expected data.
  always @(posedge clk) begin
    if (rst) begin
      exp_busy <= 1'b0;
      exp_cmpl <= 1'b0;
    end else begin
      exp_cmpl <= exp_busy;
      if (exp_busy) exp_busy <= 1'b0;
      else if (cs && rd) begin
        exp_busy <= 1'b1;
        sb_q.push_back(model[addr]);
      end
    end
  end

  // Monitor: samples mid-cycle.
  always @(negedge clk) begin
    if (mon_on) begin
      chk(wait_s === !exp_busy, "R2/R3/R7/R9 wait", {31'b0, wait_s}, {31'b0, !exp_busy});
      if (exp_cmpl) begin
        if (sb_q.size() == 0) chk(1'b0, "R4 empty scoreboard", rdata, '0);
        else begin
          held = sb_q.pop_front();
          completions++;
          chk(rdata === held, "R4/R6/R9 data", rdata, held);
        end
      end else begin
        chk(rdata === held, "R5 hold", rdata, held);
      end
    end
  end

  task automatic drive(input logic c, input logic r, input logic [AW-1:0] a);
    @(posedge clk);
    #1;
    cs = c; rd = r; addr = a;
  endtask

  initial begin
    logic [AW-1:0] lf;
    #1;
    for (int i = 0; i < Depth; i++) begin
      model[i] = (i * 32'h9E37_79B9) ^ 32'h5A5A_0000 ^ i;
      uut.u_mem.mem_q[i] = model[i];
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk(wait_s === 1'b1, "R1 wait after reset", {31'b0, wait_s}, 32'd1);
    chk(rdata === '0, "R1 rdata after reset", rdata, '0);
    mon_on = 1'b1;
    // R7: idle gap
    repeat (4) drive(0, 0, '0);
    // isolated reads
    drive(1, 1, 6'd5);  drive(0, 0, '0); repeat (3) drive(0, 0, '0);
    drive(1, 1, 6'd63); drive(0, 0, '0); repeat (2) drive(0, 0, '0);
    // R8: partial strobes
    drive(1, 0, 6'd9); drive(0, 1, 6'd10); drive(1, 0, 6'd11); drive(0, 0, '0);
    repeat (2) drive(0, 0, '0);
    // R6, R9: continuous requests with a new address every cycle
    lf = 6'h2B;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[4:0], lf[5] ^ lf[4]};
      drive(1, 1, lf);
    end
    drive(0, 0, '0);
    repeat (3) drive(0, 0, '0);
    // reset in the middle of a read
    drive(1, 1, 6'd7);
    @(posedge clk); #1 rst = 1'b1; mon_on = 1'b0; cs = 0; rd = 0;
    sb_q.delete();
    @(posedge clk); #1 rst = 1'b0; held = '0;
    @(negedge clk);
    // R1
    chk(wait_s === 1'b1, "R1 wait after mid-read reset", {31'b0, wait_s}, 32'd1);
    chk(rdata === '0, "R1 rdata after mid-read reset", rdata, '0);
    mon_on = 1'b1;
    drive(1, 1, 6'd0); drive(0, 0, '0); repeat (3) drive(0, 0, '0);
    @(negedge clk);
    chk(completions >= 20, "R6 completion count", completions, 20);
    chk(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule